// File: doc/BRIEF.md
# Machine Timer with Compare Interrupt

This block keeps a 64-bit free-running tick counter and a 64-bit threshold, and asserts a level interrupt toward the processor while the count is at or above the threshold. Both quantities sit behind a 32-bit bus slave port that uses a classic single-cycle-acknowledge handshake: cyc, stb, we, adr, dat, sel and ack. Each 64-bit value is reached as two 32-bit words.

The block occupies the last sixteen bytes of the 32-bit address space, and the interconnect routes accesses in that window to it. Inside the block only address bits 3:2 are decoded. Software reads the counter to measure time. It arms an interrupt by writing a threshold, and it clears a pending interrupt by writing a larger threshold. Firmware can also preset the counter one half at a time. After reset the threshold is all ones, so the interrupt stays quiet until software programs it.

Top module: `mtmr_top`

## Requirements
- R1: While reset is high and in the first cycle after it is released, the counter is zero, the threshold is all ones, irq_o is low and ack_o is low. The first read of the low counter word after reset returns 0.
- R2: In every cycle without a counter write, the 64-bit counter advances by exactly one. From all ones it wraps to zero.
- R3: The carry out of the low counter word enters the high counter word in the same cycle.
- R4: adr_i[3:2] selects the word: 0 is the low counter word (byte address 0xFFFFFFF0), 1 is the high counter word (0xFFFFFFF4), 2 is the low threshold word (0xFFFFFFF8) and 3 is the high threshold word (0xFFFFFFFC). adr_i[1:0] and the bits above bit 3 have no effect.
- R5: A write changes only the addressed 32-bit half, and only the bytes whose sel_i bit is set, where sel_i[i] covers data bits 8i+7:8i. In a cycle where the counter is written, neither counter half increments.
- R6: When cyc_i and stb_i are high and no acknowledge is pending, ack_o rises for exactly one cycle on the next clock edge. The access takes effect once. Without cyc_i and stb_i, ack_o stays low.
- R7: While ack_o is high after a read, dat_o holds the addressed word as it was in the cycle the access was accepted, before that edge's increment.
- R8: irq_o is high exactly when the counter is greater than or equal to the threshold, as a 64-bit unsigned comparison of the current register values.
- R9: irq_o falls when the threshold is rewritten above the counter, or when the counter wraps past all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Strobe, access request for this slave |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | ADDR_W (32) | Byte address; bits 3:2 select the word |
| dat_i | input | DATA_W (32) | Write data |
| sel_i | input | DATA_W/8 (4) | Byte enables within the addressed word |
| dat_o | output | DATA_W (32) | Read data, valid while ack_o is high after a read |
| ack_o | output | 1 | One-cycle acknowledge |
| irq_o | output | 1 | Level timer interrupt request |

## Verification
A bus write to a counter half can fall in the same cycle as the counter's own increment. The bench provokes this with two back-to-back writes. The first sets the low word to 0xFFFFFFFE. The second write is accepted on the edge where a carry into the high word would otherwise happen, and the bench then reads back the high word to confirm it did not move. A threshold update and a counter change can also land in one cycle. Random accesses create that overlap continuously, and an independent cycle model in the bench judges irq_o on every cycle. Near wrap, a forced counter value shows the interrupt falling exactly when the counter rolls over.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
   // Word index taken from address bits 3:2; the order is fixed by the memory map.
   typedef enum logic [1:0] {
      MT_CNT_LO = 2'd0,
      MT_CNT_HI = 2'd1,
      MT_THR_LO = 2'd2,
      MT_THR_HI = 2'd3
   } mt_word_e;
endpackage

// File: rtl/mtmr_bus_slv.sv
module mtmr_bus_slv
   import mtmr_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              cyc_i,
   input  logic              stb_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] adr_i,
   output logic              ack_o,
   output logic              wr_go_o,
   output logic              rd_go_o,
   output mt_word_e          word_o
);
   logic ack_q;
   logic go;
   logic unused_addr_bits;

   // An access is accepted once; the acknowledge cycle blocks a repeat.
   assign go      = cyc_i & stb_i & ~ack_q;
   assign wr_go_o = go & we_i;
   assign rd_go_o = go & ~we_i;
   assign word_o  = mt_word_e'(adr_i[3:2]);
   assign ack_o   = ack_q;

   assign unused_addr_bits = ^{adr_i[ADDR_W-1:4], adr_i[1:0]};

   always_ff @(posedge clk_i) begin
      if (rst_i) ack_q <= 1'b0;
      else       ack_q <= go;
   end

   // R6: a fresh strobe is acknowledged on the following edge
   p_ack_follows_strobe_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (cyc_i && stb_i && !ack_q) |=> ack_q);
   // R6: no strobe, no acknowledge
   p_no_ack_idle_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      !(cyc_i && stb_i) |=> !ack_q);
endmodule

// File: rtl/mtmr_half_reg.sv
module mtmr_half_reg #(
   parameter int          DATA_W    = 32,
   parameter bit          COUNT_EN  = 1'b0,
   parameter logic [2*DATA_W-1:0] RESET_VAL = '0
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  logic                  wr_lo_i,
   input  logic                  wr_hi_i,
   input  logic [DATA_W/8-1:0]   be_i,
   input  logic [DATA_W-1:0]     wdata_i,
   output logic [2*DATA_W-1:0]   q_o
);
   localparam int BYTES = DATA_W / 8;
   localparam int FULL_W = 2 * DATA_W;

   logic [FULL_W-1:0] q_q;
   logic [FULL_W-1:0] merged;
   logic [1:0]        wr_half;
   logic              any_wr;

   assign wr_half = {wr_hi_i, wr_lo_i};
   assign any_wr  = wr_lo_i | wr_hi_i;
   assign q_o     = q_q;

   // Byte-lane merge: each lane of each half takes bus data only when selected.
   for (genvar h = 0; h < 2; h++) begin : g_half
      for (genvar b = 0; b < BYTES; b++) begin : g_lane
         assign merged[h*DATA_W + b*8 +: 8] =
            (wr_half[h] && be_i[b]) ? wdata_i[b*8 +: 8] : q_q[h*DATA_W + b*8 +: 8];
      end
   end

   if (COUNT_EN) begin : g_counter
      always_ff @(posedge clk_i) begin
         if (rst_i)       q_q <= RESET_VAL;
         else if (any_wr) q_q <= merged;
         else             q_q <= q_q + {{(FULL_W-1){1'b0}}, 1'b1};
      end

      // R2: one step per idle cycle, wrapping by width
      p_count_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
         !any_wr |=> q_q == $past(q_q) + {{(FULL_W-1){1'b0}}, 1'b1});
   end else begin : g_holding
      always_ff @(posedge clk_i) begin
         if (rst_i)       q_q <= RESET_VAL;
         else if (any_wr) q_q <= merged;
      end

      // R5: a register without counting holds when not written
      p_hold_unwritten_r5: assert property (@(posedge clk_i) disable iff (rst_i)
         !any_wr |=> $stable(q_q));
   end

   // R5: writing the low half leaves the high half untouched
   p_low_write_isolated_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_lo_i && !wr_hi_i) |=> q_q[FULL_W-1:DATA_W] == $past(q_q[FULL_W-1:DATA_W]));
   // R5: a deselected byte lane keeps its value
   p_lane0_masked_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_lo_i && !be_i[0]) |=> q_q[7:0] == $past(q_q[7:0]));
endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
   import mtmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic                cyc_i,
   input  logic                stb_i,
   input  logic                we_i,
   input  logic [ADDR_W-1:0]   adr_i,
   input  logic [DATA_W-1:0]   dat_i,
   input  logic [DATA_W/8-1:0] sel_i,
   output logic [DATA_W-1:0]   dat_o,
   output logic                ack_o,
   output logic                irq_o
);
   localparam int CNT_W = 2 * DATA_W;

   if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_bad_data_w
      $error("mtmr_top: DATA_W must be a positive multiple of 8");
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("mtmr_top: ADDR_W must be at least 4");
   end

   logic              wr_go, rd_go;
   mt_word_e          word;
   logic [CNT_W-1:0]  cnt_q, thr_q;
   logic              cnt_wr_lo, cnt_wr_hi, thr_wr_lo, thr_wr_hi;
   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] dat_q;

   mtmr_bus_slv #(.ADDR_W(ADDR_W)) u_bus (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .cyc_i   (cyc_i),
      .stb_i   (stb_i),
      .we_i    (we_i),
      .adr_i   (adr_i),
      .ack_o   (ack_o),
      .wr_go_o (wr_go),
      .rd_go_o (rd_go),
      .word_o  (word)
   );

   assign cnt_wr_lo = wr_go && (word == MT_CNT_LO);
   assign cnt_wr_hi = wr_go && (word == MT_CNT_HI);
   assign thr_wr_lo = wr_go && (word == MT_THR_LO);
   assign thr_wr_hi = wr_go && (word == MT_THR_HI);

   mtmr_half_reg #(.DATA_W(DATA_W), .COUNT_EN(1'b1), .RESET_VAL('0)) u_count (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .wr_lo_i (cnt_wr_lo),
      .wr_hi_i (cnt_wr_hi),
      .be_i    (sel_i),
      .wdata_i (dat_i),
      .q_o     (cnt_q)
   );

   mtmr_half_reg #(.DATA_W(DATA_W), .COUNT_EN(1'b0), .RESET_VAL('1)) u_thresh (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .wr_lo_i (thr_wr_lo),
      .wr_hi_i (thr_wr_hi),
      .be_i    (sel_i),
      .wdata_i (dat_i),
      .q_o     (thr_q)
   );

   always_comb begin
      unique case (word)
         MT_CNT_LO: rd_word = cnt_q[DATA_W-1:0];
         MT_CNT_HI: rd_word = cnt_q[CNT_W-1:DATA_W];
         MT_THR_LO: rd_word = thr_q[DATA_W-1:0];
         default:   rd_word = thr_q[CNT_W-1:DATA_W];
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)      dat_q <= '0;
      else if (rd_go) dat_q <= rd_word;
   end

   assign dat_o = dat_q;
   assign irq_o = (cnt_q >= thr_q);

   // R1: the reset values keep the interrupt quiet right after release
   p_quiet_after_reset_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> !irq_o);
   // R9: rolling past all ones lands on zero and drops the request
   p_wrap_to_zero_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (cnt_q == {CNT_W{1'b1}} && !cnt_wr_lo && !cnt_wr_hi) |=> (cnt_q == '0));
   // R7: a read of the low counter word returns the value seen at acceptance
   p_read_cnt_lo_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_go && word == MT_CNT_LO) |=> (ack_o && dat_o == $past(cnt_q[DATA_W-1:0])));
endmodule

// File: tb/tb_mtmr_top.sv
module tb_mtmr_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
   logic [31:0] adr = '0, dat = '0;
   logic [3:0]  sel = '0;
   logic [31:0] dat_o;
   logic        ack, irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   string cur_req = "R7";

   always #4 clk = ~clk;

   mtmr_top dut (
      .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
      .adr_i(adr), .dat_i(dat), .sel_i(sel), .dat_o(dat_o), .ack_o(ack), .irq_o(irq)
   );

   // ---------------- reference model from the requirements ----------------
   logic [63:0] m_cnt, m_thr;
   logic        m_ack, m_rdv;
   logic [31:0] m_rd;
   logic        m_go;
   assign m_go = cyc & stb & ~m_ack;

   function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n,
                                       input logic [3:0] s);
      logic [31:0] r;
      for (int i = 0; i < 4; i++) r[i*8 +: 8] = s[i] ? n[i*8 +: 8] : o[i*8 +: 8];
      return r;
   endfunction

   function automatic logic [31:0] pick(input logic [1:0] w, input logic [63:0] c,
                                        input logic [63:0] t);
      case (w)
         2'd0:    return c[31:0];
         2'd1:    return c[63:32];
         2'd2:    return t[31:0];
         default: return t[63:32];
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_cnt <= '0; m_thr <= '1; m_ack <= 1'b0; m_rdv <= 1'b0; m_rd <= '0;
      end else begin
         m_ack <= m_go;
         m_rdv <= m_go && !we;
         if (m_go && !we) m_rd <= pick(adr[3:2], m_cnt, m_thr);
         if (m_go && we && !adr[3])
            m_cnt <= adr[2] ? {mrg(m_cnt[63:32], dat, sel), m_cnt[31:0]}
                            : {m_cnt[63:32], mrg(m_cnt[31:0], dat, sel)};
         else
            m_cnt <= m_cnt + 64'd1;
         if (m_go && we && adr[3])
            m_thr <= adr[2] ? {mrg(m_thr[63:32], dat, sel), m_thr[31:0]}
                            : {m_thr[63:32], mrg(m_thr[31:0], dat, sel)};
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (!rst && !done) begin
         chk("R6 ack", {63'd0, ack}, {63'd0, m_ack});
         chk("R8 irq", {63'd0, irq}, {63'd0, (m_cnt >= m_thr)});
         if (ack && m_rdv) chk(cur_req, {32'd0, dat_o}, {32'd0, m_rd});
      end
   end

   // ---------------- bus tasks ----------------
   task automatic acc(input logic [31:0] a, input logic w, input logic [31:0] d,
                      input logic [3:0] s, output logic [31:0] r);
      cyc = 1'b1; stb = 1'b1; we = w; adr = a; dat = d; sel = s;
      do begin
         @(posedge clk); @(negedge clk);
      end while (!ack);
      r = dat_o;
      cyc = 1'b0; stb = 1'b0; we = 1'b0;
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
      logic [31:0] junk;
      acc(a, 1'b1, d, s, junk);
   endtask

   task automatic rd(input logic [31:0] a, output logic [31:0] r);
      acc(a, 1'b0, 32'd0, 4'h0, r);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL R6 watchdog: actual hung expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] r;
      logic [31:0] a;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state seen on the ports
      chk("R1 irq in reset", {63'd0, irq}, 64'd0);
      chk("R1 ack in reset", {63'd0, ack}, 64'd0);
      rst = 1'b0;
      cur_req = "R1";
      rd(32'hFFFF_FFF0, r);
      chk("R1 first count read", {32'd0, r}, 64'd0);
      cur_req = "R2";
      rd(32'hFFFF_FFF0, r);
      chk("R2 count after two edges", {32'd0, r}, 64'd2);
      cur_req = "R1";
      rd(32'hFFFF_FFF8, r);
      chk("R1 threshold low", {32'd0, r}, 64'hFFFF_FFFF);
      rd(32'hFFFF_FFFC, r);
      chk("R1 threshold high", {32'd0, r}, 64'hFFFF_FFFF);

      // R4: low address bits and upper bits are ignored
      cur_req = "R4";
      wr(32'h1234_567B, 32'h1234_5678, 4'hF);
      rd(32'hFFFF_FFF9, r);
      chk("R4 threshold low via aliases", {32'd0, r}, 64'h1234_5678);
      rd(32'hFFFF_FFFE, r);
      chk("R4 R5 threshold high untouched", {32'd0, r}, 64'hFFFF_FFFF);

      // R5: byte select inside a word
      cur_req = "R5";
      wr(32'hFFFF_FFFC, 32'hAABB_CCDD, 4'b0100);
      rd(32'hFFFF_FFFC, r);
      chk("R5 byte lane 2 only", {32'd0, r}, 64'hFFBB_FFFF);

      // R3: carry from low word into high word
      cur_req = "R3";
      wr(32'hFFFF_FFF4, 32'd5, 4'hF);
      wr(32'hFFFF_FFF0, 32'hFFFF_FFF0, 4'hF);
      idle(30);
      rd(32'hFFFF_FFF4, r);
      chk("R3 carry into high", {32'd0, r}, 64'd6);

      // R5: a counter write in the carry cycle suppresses the increment
      cur_req = "R5";
      wr(32'hFFFF_FFF4, 32'd9, 4'hF);
      wr(32'hFFFF_FFF0, 32'hFFFF_FFFE, 4'hF);
      wr(32'hFFFF_FFF0, 32'h0000_0100, 4'hF);
      rd(32'hFFFF_FFF4, r);
      chk("R5 no carry on write cycle", {32'd0, r}, 64'd9);

      // R8 / R9 / R2: run up to the wrap point
      cur_req = "R9";
      wr(32'hFFFF_FFFC, 32'hFFFF_FFFF, 4'hF);
      wr(32'hFFFF_FFF8, 32'hFFFF_FF00, 4'hF);
      wr(32'hFFFF_FFF4, 32'hFFFF_FFFF, 4'hF);
      wr(32'hFFFF_FFF0, 32'hFFFF_FF80, 4'hF);
      chk("R8 irq at or above threshold", {63'd0, irq}, 64'd1);
      idle(200);
      chk("R9 irq drops after wrap", {63'd0, irq}, 64'd0);
      cur_req = "R2";
      rd(32'hFFFF_FFF4, r);
      chk("R2 high word after wrap", {32'd0, r}, 64'd0);

      cur_req = "R8";
      wr(32'hFFFF_FFFC, 32'd0, 4'hF);
      wr(32'hFFFF_FFF8, 32'h10, 4'hF);
      chk("R8 irq after lowering threshold", {63'd0, irq}, 64'd1);
      cur_req = "R9";
      wr(32'hFFFF_FFF8, 32'hFFFF_0000, 4'hF);
      chk("R9 irq after raising threshold", {63'd0, irq}, 64'd0);

      // Random mix, judged every cycle by the model
      cur_req = "R7";
      for (int i = 0; i < 500; i++) begin
         logic [1:0] w;
         logic       iw;
         logic [31:0] d;
         w  = 2'($urandom_range(0, 3));
         iw = 1'($urandom_range(0, 1));
         a  = {$urandom_range(0, 32'h0FFF_FFFF) , w, 2'($urandom_range(0, 3))} ;
         if (w[0]) d = 32'($urandom_range(0, 1));
         else      d = (w[1] ? m_cnt[31:0] : 32'd0) + 32'($urandom_range(0, 64));
         if ($urandom_range(0, 3) == 0) begin
            cyc = 1'b1;
            idle($urandom_range(1, 3));
            cyc = 1'b0;
         end
         idle($urandom_range(0, 3));
         if (iw) wr(a, d, 4'($urandom_range(0, 15)));
         else    rd(a, r);
      end
      idle(4);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule